// File: doc/BRIEF.md
# Programmable 24-bit Down-Counting Timer

This block is a register-mapped timer for a byte-wide synchronous bus. Software loads a 24-bit start value into three byte registers, picks a clock source and an end-of-count policy, and sets the run bit. The counter then steps down once per 32 system clocks, once per 32 rising edges of an external timer input, or once per external rising edge. When it steps from one to zero it raises a zero-detect flag, which can drive an interrupt request. An 8-bit vector register supplies the interrupt vector during an acknowledge cycle.

The external input is brought into the clock domain through a two-stage synchronizer with a rising-edge detector. At zero the counter either reloads the start value or wraps to all ones. Leaving the halt state always reloads the start value first. The live count can be read byte by byte. Below each three-byte group sits a null byte that reads zero.

Top module: `tmr24_top`

## Requirements
- R1: After reset the control register (address 0x0) reads 0x00, so the timer is halted; the status register (address 0xA) reads 0x00 and `irq` is low.
- R2: Start-value bytes high, middle and low sit at addresses 0x3, 0x4 and 0x5. They are readable and writable at any time and keep their contents through reset.
- R3: Addresses 0x2 and 0x6 always read 0x00, and writes to them change no register.
- R4: Addresses 0x7, 0x8 and 0x9 return the high, middle and low byte of the live count; writes to them change nothing.
- R5: Control bit 0 is run (1) or halt (0). In halt the count holds. On the first clock edge that sees run after halt, the count loads the start value and the prescaler restarts at 31.
- R6: With control bits [2:1] = 00 the 5-bit prescaler counts system clocks, and the counter steps on every 32nd clock after the load.
- R7: With control bits [2:1] = 01 the prescaler counts synchronized rising edges of `ext_in`, and the counter steps on every 32nd edge.
- R8: With control bits [2:1] = 10 or 11 every synchronized rising edge of `ext_in` steps the counter directly. The step lands on the second clock edge after the first edge that samples `ext_in` high.
- R9: A step from zero loads the start value when control bit 3 is 1, and 0xFFFFFF when it is 0.
- R10: Status bit 0 (zero-detect) is set only by a step from 0x000001 to 0x000000.
- R11: Zero-detect is cleared while halted, and by a status write with bit 0 = 1. A write with bit 0 = 0 has no effect. If a setting step and a clearing write fall on the same edge, the flag ends set.
- R12: `irq` is high exactly when zero-detect is set and control bit 4 (interrupt enable) is 1.
- R13: The vector register at address 0x1 resets to 0x0F. Its stored value appears on `rdata` both for a normal read and whenever `iack` is high; `iack` takes priority over the read address.
- R14: A start value of zero is unsupported but defined. When the count is zero and the start value is zero, a step leaves the count at zero in both end-of-count modes, and the flag is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address |
| we | input | 1 | Write strobe, captured on the rising clock edge |
| re | input | 1 | Read strobe; `rdata` is combinational |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, vector during acknowledge, else zero |
| ext_in | input | 1 | Raw external timer input |
| iack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request |

## Verification
The step from one to zero, which sets zero-detect, can land on the same clock edge as a software write that clears it. The bench reaches this in direct-edge mode. It raises `ext_in` with the count at one and, knowing the two-register synchronizer delay, places a status write of 0x01 on exactly the edge where the step lands. The flag must read set afterwards, and a second write must then clear it.

// File: rtl/tmr24_pkg.sv
package tmr24_pkg;
    localparam int CNT_W   = 24;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int NBYTES  = CNT_W / BYTE_W;

    typedef enum logic [1:0] {
        SRC_SYS_PRE = 2'b00,
        SRC_EXT_PRE = 2'b01,
        SRC_EXT_DIR = 2'b10,
        SRC_EXT_ALT = 2'b11
    } clk_src_e;

    typedef struct packed {
        logic     irq_en;
        logic     reload;
        clk_src_e src;
        logic     run;
    } ctrl_t;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'h0;
    localparam logic [ADDR_W-1:0] A_VECTOR = 4'h1;
    localparam logic [ADDR_W-1:0] A_PNULL  = 4'h2;
    localparam logic [ADDR_W-1:0] A_PHI    = 4'h3;
    localparam logic [ADDR_W-1:0] A_PMID   = 4'h4;
    localparam logic [ADDR_W-1:0] A_PLO    = 4'h5;
    localparam logic [ADDR_W-1:0] A_CNULL  = 4'h6;
    localparam logic [ADDR_W-1:0] A_CHI    = 4'h7;
    localparam logic [ADDR_W-1:0] A_CMID   = 4'h8;
    localparam logic [ADDR_W-1:0] A_CLO    = 4'h9;
    localparam logic [ADDR_W-1:0] A_STATUS = 4'hA;

    localparam logic [BYTE_W-1:0] VECTOR_RST = 8'h0F;

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [CNT_W-1:0] v, input int idx);
        return v[idx*BYTE_W +: BYTE_W];
    endfunction

    function automatic logic is_direct(input clk_src_e s);
        return s[1];
    endfunction
endpackage

// File: rtl/tmr24_sync_edge.sv
module tmr24_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    // newest synchronized sample high, one older sample low
    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/tmr24_prescaler.sv
module tmr24_prescaler #(
    parameter int PRE_W = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick,
    output logic wrap
);
    logic [PRE_W-1:0] pre_q;

    assign wrap = tick && (pre_q == '0);

    always_ff @(posedge clk) begin
        if (rst || restart) pre_q <= '1;
        else if (tick)      pre_q <= pre_q - 1'b1;
    end
endmodule

// File: rtl/tmr24_counter.sv
module tmr24_counter
    import tmr24_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             step,
    input  logic             reload,
    input  logic [CNT_W-1:0] preload,
    input  logic             clr_req,
    output logic [CNT_W-1:0] count,
    output logic             loaded,
    output logic             zflag
);
    logic [CNT_W-1:0] nxt;
    logic             hit_zero;

    always_comb begin
        nxt = count - 1'b1;
        if (count == '0) begin
            if (preload == '0) nxt = '0;
            else if (reload)   nxt = preload;
            else               nxt = '1;
        end
    end

    assign hit_zero = step && (count == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            loaded <= 1'b0;
            zflag  <= 1'b0;
        end else if (!run) begin
            loaded <= 1'b0;
            zflag  <= 1'b0;
        end else if (!loaded) begin
            loaded <= 1'b1;
            count  <= preload;
            if (clr_req) zflag <= 1'b0;
        end else begin
            if (step) count <= nxt;
            if (hit_zero)     zflag <= 1'b1;
            else if (clr_req) zflag <= 1'b0;
        end
    end
endmodule

// File: rtl/tmr24_top.sv
module tmr24_top
    import tmr24_pkg::*;
#(
    parameter int PRE_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              ext_in,
    input  logic              iack,
    output logic              irq
);
    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] vector_q;
    logic [BYTE_W-1:0] pre_b [NBYTES];
    logic [CNT_W-1:0]  preload;
    logic [CNT_W-1:0]  count;
    logic              loaded, zflag;
    logic              ext_rise, pre_wrap, pre_tick, step, clr_req, active;

    // control and vector registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            vector_q <= VECTOR_RST;
        end else if (we) begin
            if (addr == A_CTRL)   ctrl_q   <= ctrl_t'(wdata[$bits(ctrl_t)-1:0]);
            if (addr == A_VECTOR) vector_q <= wdata;
        end
    end

    // start-value bytes: deliberately untouched by reset
    genvar gi;
    generate
        for (gi = 0; gi < NBYTES; gi++) begin : g_pre
            localparam logic [ADDR_W-1:0] MY_ADDR = A_PLO - ADDR_W'(gi);
            always_ff @(posedge clk) begin
                if (we && addr == MY_ADDR) pre_b[gi] <= wdata;
            end
            assign preload[gi*BYTE_W +: BYTE_W] = pre_b[gi];
        end
    endgenerate

    assign clr_req = we && (addr == A_STATUS) && wdata[0];
    assign active  = ctrl_q.run && loaded;

    tmr24_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (ext_in),
        .rise(ext_rise)
    );

    assign pre_tick = (ctrl_q.src == SRC_SYS_PRE) ? 1'b1 : ext_rise;

    tmr24_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .restart(!active),
        .tick   (pre_tick),
        .wrap   (pre_wrap)
    );

    assign step = active && (is_direct(ctrl_q.src) ? ext_rise : pre_wrap);

    tmr24_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (ctrl_q.run),
        .step   (step),
        .reload (ctrl_q.reload),
        .preload(preload),
        .clr_req(clr_req),
        .count  (count),
        .loaded (loaded),
        .zflag  (zflag)
    );

    assign irq = zflag && ctrl_q.irq_en;

    always_comb begin
        rdata = '0;
        if (iack) begin
            rdata = vector_q;
        end else if (re) begin
            unique case (addr)
                A_CTRL:   rdata = BYTE_W'(ctrl_q);
                A_VECTOR: rdata = vector_q;
                A_PHI:    rdata = pick_byte(preload, 2);
                A_PMID:   rdata = pick_byte(preload, 1);
                A_PLO:    rdata = pick_byte(preload, 0);
                A_CHI:    rdata = pick_byte(count, 2);
                A_CMID:   rdata = pick_byte(count, 1);
                A_CLO:    rdata = pick_byte(count, 0);
                A_STATUS: rdata = {{(BYTE_W-1){1'b0}}, zflag};
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tmr24_chk.sv
module tmr24_chk
    import tmr24_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic              irq_en,
    input logic              flag,
    input logic              irq,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  preload,
    input logic [BYTE_W-1:0] vector
);
    p_halt_holds_r5: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(count));

    p_flag_rise_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> ($past(count) == CNT_W'(1) && count == '0));

    p_halt_clears_r11: assert property (@(posedge clk) disable iff (rst)
        !run |=> !flag);

    p_irq_on_zero_r12: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && run && irq_en && $past(preload) != '0 &&
         $past(count) == CNT_W'(1) && count == '0) |-> irq);

    p_vector_reset_r13: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> vector == VECTOR_RST);

    p_zero_hold_r14: assert property (@(posedge clk) disable iff (rst)
        (run && preload == '0 && count == '0) |=> (count == '0 && !$rose(flag)));
endmodule

bind tmr24_top tmr24_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .run    (ctrl_q.run),
    .irq_en (ctrl_q.irq_en),
    .flag   (zflag),
    .irq    (irq),
    .count  (count),
    .preload(preload),
    .vector (vector_q)
);

// File: tb/sim_tmr24_top.sv
module sim_tmr24_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] addr = '0;
    logic       we = 1'b0, re = 1'b0, ext_in = 1'b0, iack = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr24_top u0 (
        .clk(clk), .rst(rst), .addr(addr), .we(we), .re(re), .wdata(wdata),
        .rdata(rdata), .ext_in(ext_in), .iack(iack), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr = a; re = 1'b1;
        #1 d = rdata;
        re = 1'b0;
    endtask

    task automatic rd_count(output logic [23:0] c);
        logic [7:0] h, m, l;
        rd(4'h7, h); rd(4'h8, m); rd(4'h9, l);
        c = {h, m, l};
    endtask

    task automatic set_pre(input logic [23:0] v);
        wr(4'h3, v[23:16]); wr(4'h4, v[15:8]); wr(4'h5, v[7:0]);
    endtask

    task automatic pulse_ext();
        ext_in = 1'b1;
        repeat (3) @(negedge clk);
        ext_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(4'h0, d); chk("R1 ctrl after reset", d, 8'h00);
        rd(4'hA, d); chk("R1 status after reset", d, 8'h00);
        chk("R1 irq after reset", irq, 1'b0);
        rd(4'h1, d); chk("R13 vector reset value", d, 8'h0F);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        set_pre(24'hABCDEF);
        rd(4'h3, d); chk("R2 preload high", d, 8'hAB);
        rd(4'h4, d); chk("R2 preload mid", d, 8'hCD);
        rd(4'h5, d); chk("R2 preload low", d, 8'hEF);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        rd(4'h3, d); chk("R2 preload high kept through reset", d, 8'hAB);
        rd(4'h5, d); chk("R2 preload low kept through reset", d, 8'hEF);
        wr(4'h2, 8'h55);
        rd(4'h2, d); chk("R3 preload null reads zero", d, 8'h00);
        rd(4'h3, d); chk("R3 null write left high byte", d, 8'hAB);
        wr(4'h6, 8'h55);
        rd(4'h6, d); chk("R3 count null reads zero", d, 8'h00);
        wr(4'h1, 8'h42);
        rd(4'h1, d); chk("R13 vector normal read", d, 8'h42);
        iack = 1'b1; addr = 4'h5;
        #1 chk("R13 vector on acknowledge", rdata, 8'h42);
        iack = 1'b0;
    endtask

    task automatic t_direct();
        logic [23:0] c; logic [7:0] d;
        wr(4'h0, 8'h00);
        set_pre(24'h000004);
        wr(4'h0, 8'h0D);
        @(negedge clk);
        rd_count(c); chk("R5 load on first run cycle", c, 24'h000004);
        wr(4'h9, 8'h77);
        rd_count(c); chk("R4 count write ignored", c, 24'h000004);
        pulse_ext();
        rd_count(c); chk("R8 direct edge step", c, 24'h000003);
        pulse_ext(); pulse_ext();
        rd_count(c); chk("R8 two more steps", c, 24'h000001);
        rd(4'hA, d); chk("R10 flag clear before zero", d, 8'h00);
        pulse_ext();
        rd(4'hA, d); chk("R10 flag set on 1 to 0", d, 8'h01);
        chk("R12 irq masked", irq, 1'b0);
        wr(4'h0, 8'h1D);
        chk("R12 irq with enable", irq, 1'b1);
        pulse_ext();
        rd_count(c); chk("R9 reload at zero", c, 24'h000004);
        rd(4'hA, d); chk("R10 flag kept on reload step", d, 8'h01);
        wr(4'hA, 8'h00);
        rd(4'hA, d); chk("R11 write 0 no effect", d, 8'h01);
        wr(4'hA, 8'h01);
        rd(4'hA, d); chk("R11 write 1 clears", d, 8'h00);
        chk("R12 irq drops with flag", irq, 1'b0);
    endtask

    task automatic t_conflict();
        logic [23:0] c; logic [7:0] d;
        pulse_ext(); pulse_ext(); pulse_ext();
        rd_count(c); chk("R8 count at one before conflict", c, 24'h000001);
        ext_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        addr = 4'hA; wdata = 8'h01; we = 1'b1;
        @(negedge clk);
        we = 1'b0; ext_in = 1'b0;
        repeat (3) @(negedge clk);
        rd_count(c); chk("R8 step landed on write edge", c, 24'h000000);
        rd(4'hA, d); chk("R11 set wins over same-edge clear", d, 8'h01);
        wr(4'hA, 8'h01);
        rd(4'hA, d); chk("R11 later clear works", d, 8'h00);
    endtask

    task automatic t_halt();
        logic [23:0] c; logic [7:0] d;
        repeat (5) pulse_ext();
        rd(4'hA, d); chk("R10 flag set again", d, 8'h01);
        wr(4'h0, 8'h00);
        @(negedge clk);
        rd(4'hA, d); chk("R11 halt clears flag", d, 8'h00);
        pulse_ext();
        rd_count(c); chk("R5 count holds in halt", c, 24'h000000);
    endtask

    task automatic t_rollover();
        logic [23:0] c; logic [7:0] d;
        set_pre(24'h000002);
        wr(4'h0, 8'h05);
        @(negedge clk);
        rd_count(c); chk("R5 load after halt", c, 24'h000002);
        pulse_ext(); pulse_ext(); pulse_ext();
        rd_count(c); chk("R9 roll over to all ones", c, 24'hFFFFFF);
        rd(4'hA, d); chk("R10 flag from roll-over run", d, 8'h01);
        wr(4'h0, 8'h00);
    endtask

    task automatic t_zero_pre();
        logic [23:0] c; logic [7:0] d;
        set_pre(24'h000000);
        wr(4'h0, 8'h0D);
        pulse_ext(); pulse_ext(); pulse_ext();
        rd_count(c); chk("R14 zero start holds, reload mode", c, 24'h000000);
        rd(4'hA, d); chk("R14 no flag, reload mode", d, 8'h00);
        wr(4'h0, 8'h00);
        wr(4'h0, 8'h05);
        pulse_ext(); pulse_ext();
        rd_count(c); chk("R14 zero start holds, roll-over mode", c, 24'h000000);
        rd(4'hA, d); chk("R14 no flag, roll-over mode", d, 8'h00);
        wr(4'h0, 8'h00);
    endtask

    task automatic t_sysclk();
        logic [23:0] c;
        set_pre(24'h000003);
        wr(4'h0, 8'h09);
        repeat (32) @(negedge clk);
        rd_count(c); chk("R6 no step before 32 clocks", c, 24'h000003);
        @(negedge clk);
        rd_count(c); chk("R6 step at 32nd clock", c, 24'h000002);
        wr(4'h0, 8'h00);
    endtask

    task automatic t_ext_pre();
        logic [23:0] c;
        set_pre(24'h000002);
        wr(4'h0, 8'h0B);
        repeat (40) @(negedge clk);
        rd_count(c); chk("R7 system clock ignored", c, 24'h000002);
        repeat (31) pulse_ext();
        rd_count(c); chk("R7 no step after 31 edges", c, 24'h000002);
        pulse_ext();
        rd_count(c); chk("R7 step on 32nd edge", c, 24'h000001);
        wr(4'h0, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        t_reset();
        t_regs();
        t_direct();
        t_conflict();
        t_halt();
        t_rollover();
        t_zero_pre();
        t_sysclk();
        t_ext_pre();
        finish_run();
    end
endmodule